// File: doc/BRIEF.md
# Paced Double-Edge Data-In Transmitter

This block is the sending engine on the target side of a 16-bit parallel bus during a data-in phase. It puts one word on the bus for every edge of REQ, on the rising edge as well as the falling one. It takes the words from a local valid/ready stream and asserts P1 for as long as the burst runs. The stream's last flag closes the burst. If a burst has an odd number of words, the block adds one closing REQ negation and leaves the final word unchanged on the bus during it. P1 drops only once the initiator has answered every REQ assert/negate pair with an ACK.

The block counts how many pairs are still waiting for an ACK. Once that count reaches the parameterised offset limit, it starts no new pair. Each change on the phase lines opens a quiet window of bus-settle plus data-release cycles. During that window REQ does not move, no burst starts, and ACK edges are thrown away. The hold time and both delays are parameters counted in clock cycles.

Top module: `dtp_pacer_tx`

## Requirements
- R1: While rst_n is low, req_out, p1_out and s_ready are 0 and db_out is all zeros.
- R2: Each REQ edge (rise or fall) that carries a word presents the next accepted stream word on db_out, in acceptance order, and db_out changes only at REQ edges.
- R3: Two consecutive REQ edges are at least HOLD_CYC clock cycles apart. The first REQ edge of a burst comes at least HOLD_CYC cycles after P1 rises.
- R4: P1 is high whenever REQ changes, and P1 rises before the first REQ edge of a burst.
- R5: After the word marked last, P1 falls only when no REQ pair is left without an ACK, and REQ is low at that moment.
- R6: A burst with an odd number of words ends with one extra REQ negation, and db_out keeps the last word during that negation.
- R7: The count of completed REQ pairs not yet acknowledged never exceeds OFFSET_MAX. At the limit no new REQ assertion is made until an ACK arrives.
- R8: After any change of {cd_in, io_in, msg_in}, neither REQ nor P1 rises for SETTLE_CYC+RELEASE_CYC cycles.
- R9: An ACK rising edge inside that quiet window does not count as a response.
- R10: A burst starts, and stream words are accepted, only while {cd_in, io_in, msg_in} equals 3'b010 (data-in). With any other value, s_ready stays 0 and P1 stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_valid | input | 1 | Stream word available |
| s_data | input | DATA_W | Stream word |
| s_last | input | 1 | Marks the final word of a burst |
| s_ready | output | 1 | Word is taken at this clock edge |
| ack_in | input | 1 | Initiator acknowledge, one rise per REQ pair |
| cd_in | input | 1 | Phase line control/data |
| io_in | input | 1 | Phase line direction |
| msg_in | input | 1 | Phase line message |
| req_out | output | 1 | Request strobe, toggled once per word |
| p1_out | output | 1 | High while the burst's data is valid |
| db_out | output | DATA_W | Bus data lines |

## Verification
All bus outputs are registered. A word accepted at one rising edge therefore shows up on db_out and as a REQ edge on the falling edge that follows, and the next edge can come no sooner than HOLD_CYC cycles after that. P1 rises one clock after a start is allowed. The quiet window opens in the same cycle as the phase-line change, so the earliest P1 rise is the (SETTLE_CYC+RELEASE_CYC+2)-th edge after it. The bench drives and samples only at the falling clock edge, so every registered result it looks at has settled by then. It logs each REQ edge as it sees it, counts the cycles between edges itself, and models the initiator's outstanding pairs from its own ACK pulses.

// File: rtl/dtp_pkg.sv
// Shared definitions for the paced data-in transmitter.
// Assumes the phase lines are ordered {cd, io, msg}.
package dtp_pkg;

    // Phase-line code of the data-in phase: io high, cd and msg low.
    localparam logic [2:0] PH_DATA_IN = 3'b010;

    // Burst sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE,   // P1 low, waiting for a word
        ST_RUN,    // streaming words on REQ edges
        ST_PAD,    // odd count: one closing REQ negation pending
        ST_DRAIN   // waiting for the last ACKs before dropping P1
    } seq_state_t;

endpackage

// File: rtl/dtp_settle_timer.sv
// Quiet-window timer and ACK edge filter.
// Any change of the phase lines (re)starts a window of WIN_CYC cycles.
// While the window runs, quiet is high and ACK rising edges are dropped.
// Assumes ack_in and phase lines are already synchronous to clk.
module dtp_settle_timer #(
    parameter int WIN_CYC = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] phase_in,
    input  logic       ack_in,
    output logic       quiet,
    output logic       ack_evt
);
    localparam int CW = $clog2(WIN_CYC + 1);
    localparam logic [CW-1:0] WIN_V = CW'(WIN_CYC);

    logic [2:0]    ph_q;
    logic [CW-1:0] win_cnt;
    logic          ack_q;
    logic          ph_change;

    // Detect a change of the phase lines against last cycle's value.
    always_comb ph_change = (phase_in != ph_q);

    // The window covers the change cycle itself and WIN_CYC cycles after it.
    always_comb quiet = ph_change || (win_cnt != '0);

    // A counted ACK is a rising edge seen outside the window.
    always_comb ack_evt = ack_in && !ack_q && !quiet;

    // Track phase lines and run the window down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q    <= PH_RESET;
            win_cnt <= '0;
        end else begin
            ph_q <= phase_in;
            if (ph_change)
                win_cnt <= WIN_V;
            else if (win_cnt != '0)
                win_cnt <= win_cnt - CW'(1);
        end
    end

    // Keep the previous ACK level, also inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_q <= 1'b0;
        else        ack_q <= ack_in;
    end

    localparam logic [2:0] PH_RESET = 3'b000;
endmodule

// File: rtl/dtp_credit_ctr.sv
// Outstanding REQ-pair counter.
// Counts up on each completed REQ assert/negate pair and down on each
// accepted ACK. An ACK that arrives with nothing outstanding is dropped.
// Assumes the sequencer never completes a pair when room is low.
module dtp_credit_ctr #(
    parameter int LIMIT = 4,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pair_done,
    input  logic          ack_evt,
    output logic [CW-1:0] count,
    output logic          room,
    output logic          empty
);
    localparam logic [CW-1:0] LIMIT_V = CW'(LIMIT);

    logic dec;

    // An ACK only retires a pair that exists.
    always_comb dec = ack_evt && (count != '0);

    // Status seen by the sequencer.
    always_comb begin
        room  = (count < LIMIT_V);
        empty = (count == '0);
    end

    // Up/down counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            case ({pair_done, dec})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/dtp_edge_seq.sv
// Burst sequencer: turns stream words into double-edge REQ transfers.
// One word is accepted per REQ edge; db_out and req_out change together.
// Edges are spaced by HOLD_CYC cycles and are blocked during the quiet
// window, outside the data-in phase, and (for new pairs) when no room.
// Assumes HOLD_CYC >= 1.
module dtp_edge_seq
    import dtp_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int HOLD_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_last,
    output logic              s_ready,
    input  logic              phase_ok,
    input  logic              quiet,
    input  logic              room,
    input  logic              empty,
    output logic              pair_done,
    output logic              req_out,
    output logic              p1_out,
    output logic [DATA_W-1:0] db_out
);
    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam logic [HW-1:0] HOLD_LOAD = HW'(HOLD_CYC - 1);

    seq_state_t    state;
    logic [HW-1:0] hold_cnt;
    logic          edge_ok;
    logic          start;
    logic          take;
    logic          pad_edge;
    logic          close;
    logic          hold_load;

    // Decide which transitions are allowed this cycle.
    always_comb begin
        edge_ok   = (hold_cnt == '0) && !quiet && phase_ok;
        start     = (state == ST_IDLE) && s_valid && phase_ok && !quiet;
        s_ready   = (state == ST_RUN) && edge_ok && (req_out || room);
        take      = s_ready && s_valid;
        pad_edge  = (state == ST_PAD) && edge_ok;
        close     = (state == ST_DRAIN) && empty;
        pair_done = (take && req_out) || pad_edge;
        hold_load = start || take || pad_edge;
    end

    // Hold-time counter: reloaded on every edge and on burst start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_cnt <= '0;
        else if (hold_load)
            hold_cnt <= HOLD_LOAD;
        else if (hold_cnt != '0)
            hold_cnt <= hold_cnt - HW'(1);
    end

    // State and registered bus outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            req_out <= 1'b0;
            p1_out  <= 1'b0;
            db_out  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        p1_out <= 1'b1;
                        state  <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (take) begin
                        req_out <= !req_out;
                        db_out  <= s_data;
                        if (s_last)
                            state <= req_out ? ST_DRAIN : ST_PAD;
                    end
                end
                ST_PAD: begin
                    if (pad_edge) begin
                        req_out <= 1'b0;
                        state   <= ST_DRAIN;
                    end
                end
                ST_DRAIN: begin
                    if (close) begin
                        p1_out <= 1'b0;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dtp_pacer_tx.sv
// Top of the paced double-edge target transmitter.
// Joins the quiet-window timer, the outstanding-pair counter and the
// burst sequencer. Phase lines decide whether data-in bursts may run.
// Assumes all inputs are synchronous to clk.
module dtp_pacer_tx
    import dtp_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int HOLD_CYC    = 2,
    parameter int SETTLE_CYC  = 4,
    parameter int RELEASE_CYC = 3,
    parameter int OFFSET_MAX  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_last,
    output logic              s_ready,
    input  logic              ack_in,
    input  logic              cd_in,
    input  logic              io_in,
    input  logic              msg_in,
    output logic              req_out,
    output logic              p1_out,
    output logic [DATA_W-1:0] db_out
);
    localparam int WIN_CYC = SETTLE_CYC + RELEASE_CYC;
    localparam int CNT_W   = $clog2(OFFSET_MAX + 1);

    logic [2:0]       phase;
    logic             phase_ok;
    logic             quiet_win;
    logic             ack_evt;
    logic             pair_done;
    logic [CNT_W-1:0] pair_cnt;
    logic             room;
    logic             empty;

    // Gather the phase lines and decode the data-in phase.
    always_comb begin
        phase    = {cd_in, io_in, msg_in};
        phase_ok = (phase == PH_DATA_IN);
    end

    dtp_settle_timer #(
        .WIN_CYC (WIN_CYC)
    ) u_settle (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_in (phase),
        .ack_in   (ack_in),
        .quiet    (quiet_win),
        .ack_evt  (ack_evt)
    );

    dtp_credit_ctr #(
        .LIMIT (OFFSET_MAX),
        .CW    (CNT_W)
    ) u_credit (
        .clk       (clk),
        .rst_n     (rst_n),
        .pair_done (pair_done),
        .ack_evt   (ack_evt),
        .count     (pair_cnt),
        .room      (room),
        .empty     (empty)
    );

    dtp_edge_seq #(
        .DATA_W   (DATA_W),
        .HOLD_CYC (HOLD_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_valid   (s_valid),
        .s_data    (s_data),
        .s_last    (s_last),
        .s_ready   (s_ready),
        .phase_ok  (phase_ok),
        .quiet     (quiet_win),
        .room      (room),
        .empty     (empty),
        .pair_done (pair_done),
        .req_out   (req_out),
        .p1_out    (p1_out),
        .db_out    (db_out)
    );
endmodule

// File: rtl/dtp_pacer_tx_chk.sv
// Property checker for dtp_pacer_tx, attached with bind below.
// Watches the bus outputs, the quiet window and the pair counter.
module dtp_pacer_tx_chk #(
    parameter int DATA_W     = 16,
    parameter int HOLD_CYC   = 2,
    parameter int OFFSET_MAX = 4,
    parameter int CNT_W      = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_out,
    input logic              p1_out,
    input logic [DATA_W-1:0] db_out,
    input logic              quiet,
    input logic [CNT_W-1:0]  out_cnt
);
    localparam int GW = $clog2(HOLD_CYC + 2);
    localparam logic [GW-1:0] GAP_MAX = GW'(HOLD_CYC + 1);
    localparam logic [GW-1:0] GAP_MIN = GW'(HOLD_CYC);

    logic          req_d;
    logic [GW-1:0] gap;

    // Count cycles since the last REQ edge, saturating above the hold time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_d <= 1'b0;
            gap   <= GAP_MAX;
        end else begin
            req_d <= req_out;
            if (req_out != req_d)
                gap <= GW'(1);
            else if (gap < GAP_MAX)
                gap <= gap + GW'(1);
        end
    end

    // R2
    db_at_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(db_out) |-> !$stable(req_out));

    // R3
    hold_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_out != req_d) |-> (gap >= GAP_MIN));

    // R4
    p1_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(req_out) |-> p1_out);

    // R5
    close_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(p1_out) |-> ((out_cnt == '0) && !req_out));

    // R7
    offset_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_cnt <= CNT_W'(OFFSET_MAX));

    // R8
    req_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_out) |-> !$past(quiet));

    // R8
    p1_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(p1_out) |-> !$past(quiet));
endmodule

bind dtp_pacer_tx dtp_pacer_tx_chk #(
    .DATA_W     (DATA_W),
    .HOLD_CYC   (HOLD_CYC),
    .OFFSET_MAX (OFFSET_MAX),
    .CNT_W      (CNT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_out (req_out),
    .p1_out  (p1_out),
    .db_out  (db_out),
    .quiet   (quiet_win),
    .out_cnt (pair_cnt)
);

// File: tb/dtp_pacer_tx_test.sv
// Bench for dtp_pacer_tx: acts as stream source and as bus initiator.
module dtp_pacer_tx_test;
    localparam int DATA_W      = 16;
    localparam int HOLD_CYC    = 2;
    localparam int SETTLE_CYC  = 4;
    localparam int RELEASE_CYC = 3;
    localparam int OFFSET_MAX  = 4;
    localparam int WIN         = SETTLE_CYC + RELEASE_CYC;

    // Stimulus/expectation table: burst length, base word, expected REQ edges.
    localparam int NB = 4;
    localparam int          BURST_LEN [NB] = '{4, 5, 1, 8};
    localparam logic [15:0] BURST_BASE[NB] = '{16'hA5A5, 16'h0F0F, 16'hFFFF, 16'h1234};
    localparam int          EXP_EDGES [NB] = '{4, 6, 2, 8};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              s_valid = 1'b0;
    logic [DATA_W-1:0] s_data = '0;
    logic              s_last = 1'b0;
    logic              s_ready;
    logic              ack_in = 1'b0;
    logic              cd_in = 1'b0;
    logic              io_in = 1'b1;
    logic              msg_in = 1'b0;
    logic              req_out;
    logic              p1_out;
    logic [DATA_W-1:0] db_out;

    int checks = 0;
    int fails = 0;

    logic [DATA_W-1:0] exp_q[$];
    logic [DATA_W-1:0] last_word = '0;
    int  burst_edges = 0;
    int  gap = 0;
    int  pairs_done = 0;
    int  acks_given = 0;
    int  pending = 0;
    int  manual = 0;
    bit  ack_auto = 1'b1;
    int  fall_out = -1;
    int  fall_req = -1;
    logic req_p = 1'b0;
    logic p1_p = 1'b0;

    dtp_pacer_tx #(
        .DATA_W      (DATA_W),
        .HOLD_CYC    (HOLD_CYC),
        .SETTLE_CYC  (SETTLE_CYC),
        .RELEASE_CYC (RELEASE_CYC),
        .OFFSET_MAX  (OFFSET_MAX)
    ) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_valid (s_valid),
        .s_data  (s_data),
        .s_last  (s_last),
        .s_ready (s_ready),
        .ack_in  (ack_in),
        .cd_in   (cd_in),
        .io_in   (io_in),
        .msg_in  (msg_in),
        .req_out (req_out),
        .p1_out  (p1_out),
        .db_out  (db_out)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] word_of(input logic [15:0] base, input int i);
        return base ^ 16'(i * 16'h1357);
    endfunction

    // Bus monitor and initiator model, all at the falling edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            req_p  = 1'b0;
            p1_p   = 1'b0;
            gap    = 0;
            ack_in = 1'b0;
        end else begin
            gap++;
            if (p1_out && !p1_p) gap = 0;
            if (!p1_out && p1_p) begin
                fall_out = pairs_done - acks_given;
                fall_req = int'(req_out);
            end
            if (req_out != req_p) begin
                burst_edges++;
                check(p1_out, "R4 p1 during REQ edge", int'(p1_out), 1);
                check(gap >= HOLD_CYC, "R3 edge spacing", gap, HOLD_CYC);
                if (exp_q.size() > 0) begin
                    logic [DATA_W-1:0] w;
                    w = exp_q.pop_front();
                    check(db_out == w, "R2 word on edge", int'(db_out), int'(w));
                end else begin
                    check(!req_out && db_out == last_word, "R6 closing negation",
                          int'(db_out), int'(last_word));
                end
                gap = 0;
                if (!req_out) begin
                    pairs_done++;
                    pending++;
                end
            end
            req_p = req_out;
            p1_p  = p1_out;
            if (ack_in)
                ack_in = 1'b0;
            else if (manual > 0) begin
                ack_in = 1'b1;
                manual--;
            end else if (ack_auto && pending > 0) begin
                ack_in = 1'b1;
                pending--;
                acks_given++;
            end
        end
    end

    // Feed a burst of n words from the stream side.
    task automatic run_burst(input int n, input logic [15:0] base);
        burst_edges = 0;
        for (int i = 0; i < n; i++) begin
            s_data  = word_of(base, i);
            s_last  = (i == n - 1);
            s_valid = 1'b1;
            while (!s_ready) @(negedge clk);
            exp_q.push_back(s_data);
            last_word = s_data;
            @(negedge clk);
        end
        s_valid = 1'b0;
        s_last  = 1'b0;
    endtask

    task automatic wait_idle();
        int t = 0;
        while (p1_out && t < 500) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic set_phase(input logic [2:0] ph);
        {cd_in, io_in, msg_in} = ph;
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: outputs in reset.
        check(req_out == 1'b0, "R1 req in reset", int'(req_out), 0);
        check(p1_out == 1'b0, "R1 p1 in reset", int'(p1_out), 0);
        check(s_ready == 1'b0, "R1 ready in reset", int'(s_ready), 0);
        check(db_out == '0, "R1 db in reset", int'(db_out), 0);
        rst_n = 1'b1;
        repeat (12) @(negedge clk);

        // Table of bursts.
        for (int b = 0; b < NB; b++) begin
            fall_out = -1;
            run_burst(BURST_LEN[b], BURST_BASE[b]);
            wait_idle();
            @(negedge clk);
            check(burst_edges == EXP_EDGES[b], "R2 R6 edge count", burst_edges, EXP_EDGES[b]);
            check(fall_out == 0, "R5 no pair left at P1 fall", fall_out, 0);
            check(fall_req == 0, "R5 REQ low at P1 fall", fall_req, 0);
            check(exp_q.size() == 0, "R2 all words sent", exp_q.size(), 0);
        end

        // R7: no ACKs, so REQ stalls at the offset limit.
        ack_auto = 1'b0;
        fall_out = -1;
        fork
            run_burst(12, 16'h3C3C);
        join_none
        repeat (60) @(negedge clk);
        check(burst_edges == 2 * OFFSET_MAX, "R7 edges at limit", burst_edges, 2 * OFFSET_MAX);
        check(req_out == 1'b0, "R7 REQ held low", int'(req_out), 0);
        check(p1_out == 1'b1, "R7 burst still open", int'(p1_out), 1);
        ack_auto = 1'b1;
        wait fork;
        wait_idle();
        @(negedge clk);
        check(burst_edges == 12, "R7 burst resumes", burst_edges, 12);
        check(fall_out == 0, "R5 close after stall", fall_out, 0);

        // R9: ACKs inside a quiet window are not counted.
        ack_auto = 1'b0;
        fall_out = -1;
        run_burst(4, 16'h8001);
        repeat (20) @(negedge clk);
        check(p1_out == 1'b1, "R5 waits for ACKs", int'(p1_out), 1);
        set_phase(3'b000);
        @(negedge clk);
        set_phase(3'b010);
        manual = 2;
        repeat (20) @(negedge clk);
        check(p1_out == 1'b1, "R9 window ACKs ignored", int'(p1_out), 1);
        ack_auto = 1'b1;
        wait_idle();
        @(negedge clk);
        check(p1_out == 1'b0, "R9 real ACKs close", int'(p1_out), 0);
        check(fall_out == 0, "R5 close after window", fall_out, 0);
        repeat (12) @(negedge clk);

        // R10 and R8: no start outside data-in, then a quiet window.
        set_phase(3'b000);
        fork
            run_burst(2, 16'h5555);
        join_none
        repeat (20) @(negedge clk);
        check(p1_out == 1'b0, "R10 no start off phase", int'(p1_out), 0);
        check(s_ready == 1'b0, "R10 no accept off phase", int'(s_ready), 0);
        check(burst_edges == 0, "R10 no REQ off phase", burst_edges, 0);
        set_phase(3'b010);
        begin
            int n = 0;
            while (!p1_out && n < 100) begin
                @(negedge clk);
                n++;
            end
            check(n > WIN, "R8 start after quiet window", n, WIN + 1);
        end
        wait fork;
        wait_idle();
        @(negedge clk);
        check(burst_edges == 2, "R8 burst after window", burst_edges, 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule